// File: doc/BRIEF.md
# Status-Flag ALU with Decimal Add

This block is the arithmetic and logic stage of a small 16-bit microcontroller core. Each accepted operation takes a destination operand, a source operand, the current status word and three flag masks that the decoder supplies. The stage registers a result, a result-write strobe, an updated status word and a branch-taken bit one clock later. It handles byte and word sizes. It covers binary add and subtract with and without carry, compare, packed-decimal add, the bitwise operations, three one-bit right shifts, byte swap and sign extension.

The status word holds carry in bit 0, zero in bit 1, negative in bit 2 and overflow in bit 8. All other status bits pass through unchanged. Flag masks are four bits wide and ordered {V,N,Z,C}, with V as bit 3 and C as bit 0. The branch condition is evaluated on the incoming status word in the same cycle as the operation, so the decoder can fold a conditional jump into an idle ALU slot. Register file, operand fetch and decode sit outside.

Top module: `alu16_top`

## Requirements
- R1: While rst_n is low, out_valid, out_result, out_wr, out_sr and out_taken are all zero.
- R2: The outputs change only one clock after an edge at which in_valid is high, and out_valid equals in_valid from the previous edge. Operation codes: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 compare, 5 decimal add, 6 AND, 7 bit-test, 8 bit-clear (dst & ~src), 9 bit-set (dst | src), 10 XOR, 11 rotate right through carry, 12 arithmetic shift right, 13 logical shift right, 14 byte swap, 15 sign extend.
- R3: Add gives dst+src, and add-with-carry adds the carry bit (status bit 0) as well. The computed C is the carry out of the operand width, and the computed V is set when the signed sum does not fit that width.
- R4: Subtract and compare give dst + ~src + 1 within the width. Subtract-with-carry uses the carry bit in place of the +1. C is the carry out of that sum and V is signed overflow. Compare and bit-test drive out_wr low, and every other operation drives it high.
- R5: Decimal add reads each nibble of both operands as a decimal digit (2 digits for byte, 4 for word), adds both values and the carry bit, and returns the low digits of the sum in packed decimal. C is set when the sum exceeds 99 (byte) or 9999 (word), and V is 0.
- R6: AND, bit-test and XOR set the computed C when the result is non-zero. XOR sets V when both operands have their sign bit set. Bit-clear and bit-set compute C=0. Every logical operation computes V=0 except XOR.
- R7: Rotate through carry shifts dst right by one, inserts the old carry bit at the top bit of the operand size and moves dst bit 0 into C. The arithmetic shift keeps the sign bit, the logical shift inserts 0, and both move bit 0 into C. Shifts compute V=0.
- R8: Byte swap exchanges the two bytes of the 16-bit dst. Sign extend copies dst bit 7 into bits 15:8 and computes C as result non-zero. Both always work on the whole word, whatever the size input says, and compute V=0.
- R9: For byte size, the upper input bits are ignored and out_result[15:8] is zero, except for byte swap and sign extend. The computed N is the top bit of the operand size and the computed Z is set when all result bits within that size are zero.
- R10: A flag in the clear mask is zeroed, and a flag in the update mask is first zeroed and then given its computed value. A flag in the set mask is forced to one. A flag in no mask keeps its status value. Status bits other than 0, 1, 2 and 8 pass through from in_sr.
- R11: out_taken uses in_cond on the incoming status word: 0 Z clear, 1 Z set, 2 C clear, 3 C set, 4 N set, 5 N equals V, 6 N differs from V, 7 always.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Operation code (R2) |
| in_byte | input | 1 | 1 selects byte size, 0 word size |
| in_dst | input | 16 | Destination operand (first operand) |
| in_src | input | 16 | Source operand (second operand) |
| in_sr | input | 16 | Current status word |
| in_clr | input | 4 | Forced-zero flag mask {V,N,Z,C} |
| in_set | input | 4 | Forced-one flag mask {V,N,Z,C} |
| in_upd | input | 4 | Computed-flag update mask {V,N,Z,C} |
| in_cond | input | 3 | Branch condition code (R11) |
| out_valid | output | 1 | Registered result valid |
| out_result | output | 16 | Registered result |
| out_wr | output | 1 | Result is to be written back |
| out_sr | output | 16 | Updated status word |
| out_taken | output | 1 | Branch condition met |

## Verification
The assertions check the properties that hold for any operand values on every cycle. These are the one-cycle valid latency, the missing write strobe for compare and bit-test, the clear upper byte of byte results, forced-one flags, flags and status bits left untouched outside the masks, the zero flag agreeing with the result, and the always-true branch. The arithmetic itself needs the bench's behavioural model, and so do the carry and overflow values and the decimal digit handling. The same holds for the bit that a rotate or shift moves in, and the condition table of the conditional branches. These can only be shown by comparing directed corner cases and a long random run against that model.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,
    OP_DADD = 4'd5,
    OP_AND  = 4'd6,
    OP_BIT  = 4'd7,
    OP_BIC  = 4'd8,
    OP_BIS  = 4'd9,
    OP_XOR  = 4'd10,
    OP_RRC  = 4'd11,
    OP_RRA  = 4'd12,
    OP_RRU  = 4'd13,
    OP_SWPB = 4'd14,
    OP_SXT  = 4'd15
  } alu_op_e;

  // Flag positions inside the 16-bit status word
  localparam int SR_C = 0;
  localparam int SR_Z = 1;
  localparam int SR_N = 2;
  localparam int SR_V = 8;

  // Mask bit order {V,N,Z,C}
  localparam int MK_C = 0;
  localparam int MK_Z = 1;
  localparam int MK_N = 2;
  localparam int MK_V = 3;

  typedef enum logic [2:0] {
    CND_NZ  = 3'd0,
    CND_Z   = 3'd1,
    CND_NC  = 3'd2,
    CND_C   = 3'd3,
    CND_N   = 3'd4,
    CND_GE  = 3'd5,
    CND_LT  = 3'd6,
    CND_ALL = 3'd7
  } cond_e;

  // Weight the nibbles of v as decimal digits, most significant first.
  function automatic logic [16:0] digits_to_bin(input logic [15:0] v, input int ndig);
    logic [16:0] acc;
    acc = '0;
    for (int i = 3; i >= 0; i--) begin
      if (i < ndig) acc = acc * 17'd10 + {13'd0, v[4*i +: 4]};
    end
    return acc;
  endfunction

  // Emit the low ndig decimal digits of x as packed nibbles.
  function automatic logic [15:0] bin_to_digits(input logic [16:0] x, input int ndig);
    logic [15:0] r;
    logic [16:0] t;
    r = '0;
    t = x;
    for (int i = 0; i < 4; i++) begin
      if (i < ndig) begin
        r[4*i +: 4] = 4'(t % 17'd10);
        t = t / 17'd10;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic              byte_sz,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              c_out,
  output logic              v_out
);
  localparam int HALF_W = DATA_W / 2;
  localparam int DIG_W  = DATA_W / 4;
  localparam int DIG_B  = HALF_W / 4;

  logic              is_sub;
  logic              carry_in;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum_w;
  logic [HALF_W:0]   sum_b;
  logic              ovf_w;
  logic              ovf_b;
  logic [16:0]       dec_sum;
  logic [16:0]       dec_lim;
  logic [15:0]       dec_a;
  logic [15:0]       dec_b;

  always_comb begin
    is_sub = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
    unique case (op)
      OP_ADD:               carry_in = 1'b0;
      OP_SUB, OP_CMP:       carry_in = 1'b1;
      default:              carry_in = cin;
    endcase
  end

  assign b_eff = is_sub ? ~b : b;
  assign sum_w = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, carry_in};
  assign sum_b = {1'b0, a[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]} + {{HALF_W{1'b0}}, carry_in};

  assign ovf_w = (a[DATA_W-1] == b_eff[DATA_W-1]) && (sum_w[DATA_W-1] != a[DATA_W-1]);
  assign ovf_b = (a[HALF_W-1] == b_eff[HALF_W-1]) && (sum_b[HALF_W-1] != a[HALF_W-1]);

  // Decimal path: only the digits inside the operand size take part
  assign dec_a   = byte_sz ? {8'd0, a[7:0]} : a[15:0];
  assign dec_b   = byte_sz ? {8'd0, b[7:0]} : b[15:0];
  assign dec_sum = digits_to_bin(dec_a, byte_sz ? DIG_B : DIG_W)
                 + digits_to_bin(dec_b, byte_sz ? DIG_B : DIG_W)
                 + {16'd0, cin};
  assign dec_lim = byte_sz ? 17'd99 : 17'd9999;

  always_comb begin
    if (op == OP_DADD) begin
      res   = bin_to_digits(dec_sum, byte_sz ? DIG_B : DIG_W);
      c_out = dec_sum > dec_lim;
      v_out = 1'b0;
    end else if (byte_sz) begin
      res   = {{HALF_W{1'b0}}, sum_b[HALF_W-1:0]};
      c_out = sum_b[HALF_W];
      v_out = ovf_b;
    end else begin
      res   = sum_w[DATA_W-1:0];
      c_out = sum_w[DATA_W];
      v_out = ovf_w;
    end
  end

endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic              byte_sz,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              c_out,
  output logic              v_out
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] size_mask;
  logic [DATA_W-1:0] a_m;
  logic [DATA_W-1:0] b_m;
  logic              sign_a;
  logic              sign_b;
  logic [DATA_W-1:0] shr_base;
  logic [DATA_W-1:0] top_bit;
  logic [DATA_W-1:0] raw;

  assign size_mask = byte_sz ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : {DATA_W{1'b1}};
  assign a_m       = a & size_mask;
  assign b_m       = b & size_mask;
  assign sign_a    = byte_sz ? a[HALF_W-1] : a[DATA_W-1];
  assign sign_b    = byte_sz ? b[HALF_W-1] : b[DATA_W-1];
  assign shr_base  = a_m >> 1;
  // One-hot at the top bit of the operand size
  assign top_bit   = byte_sz ? {{HALF_W{1'b0}}, 1'b1, {(HALF_W-1){1'b0}}}
                             : {1'b1, {(DATA_W-1){1'b0}}};

  always_comb begin
    raw   = '0;
    c_out = 1'b0;
    v_out = 1'b0;
    unique case (op)
      OP_AND, OP_BIT: begin
        raw   = a_m & b_m;
        c_out = |raw;
      end
      OP_BIC: raw = a_m & ~b_m & size_mask;
      OP_BIS: raw = a_m | b_m;
      OP_XOR: begin
        raw   = a_m ^ b_m;
        c_out = |raw;
        v_out = sign_a & sign_b;
      end
      OP_RRC: begin
        raw   = shr_base | (cin ? top_bit : '0);
        c_out = a[0];
      end
      OP_RRA: begin
        raw   = shr_base | (sign_a ? top_bit : '0);
        c_out = a[0];
      end
      OP_RRU: begin
        raw   = shr_base;
        c_out = a[0];
      end
      OP_SWPB: raw = {a[HALF_W-1:0], a[DATA_W-1:HALF_W]};
      OP_SXT: begin
        raw   = {{HALF_W{a[HALF_W-1]}}, a[HALF_W-1:0]};
        c_out = |raw;
      end
      default: raw = '0;
    endcase
  end

  assign res = raw;

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MASK_W = 4
) (
  input  logic [DATA_W-1:0] res,
  input  logic              word_res,
  input  logic              calc_c,
  input  logic              calc_v,
  input  logic [DATA_W-1:0] sr_in,
  input  logic [MASK_W-1:0] clr_mask,
  input  logic [MASK_W-1:0] set_mask,
  input  logic [MASK_W-1:0] upd_mask,
  input  cond_e             cond,
  output logic [DATA_W-1:0] sr_out,
  output logic              taken
);
  localparam int HALF_W = DATA_W / 2;

  logic              calc_n;
  logic              calc_z;
  logic [MASK_W-1:0] cur_f;
  logic [MASK_W-1:0] calc_f;
  logic [MASK_W-1:0] new_f;

  assign calc_n = word_res ? res[DATA_W-1] : res[HALF_W-1];
  assign calc_z = word_res ? (res == '0) : (res[HALF_W-1:0] == '0);

  assign cur_f  = {sr_in[SR_V], sr_in[SR_N], sr_in[SR_Z], sr_in[SR_C]};
  assign calc_f = {calc_v, calc_n, calc_z, calc_c};
  // clear, then clear what gets recomputed, force ones, merge computed
  assign new_f  = (cur_f & ~clr_mask & ~upd_mask) | set_mask | (calc_f & upd_mask);

  always_comb begin
    sr_out       = sr_in;
    sr_out[SR_C] = new_f[MK_C];
    sr_out[SR_Z] = new_f[MK_Z];
    sr_out[SR_N] = new_f[MK_N];
    sr_out[SR_V] = new_f[MK_V];
  end

  always_comb begin
    unique case (cond)
      CND_NZ:  taken = ~sr_in[SR_Z];
      CND_Z:   taken =  sr_in[SR_Z];
      CND_NC:  taken = ~sr_in[SR_C];
      CND_C:   taken =  sr_in[SR_C];
      CND_N:   taken =  sr_in[SR_N];
      CND_GE:  taken = (sr_in[SR_N] == sr_in[SR_V]);
      CND_LT:  taken = (sr_in[SR_N] != sr_in[SR_V]);
      default: taken = 1'b1;
    endcase
  end

endmodule

// File: rtl/alu16_top.sv
module alu16_top
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MASK_W = 4,
  parameter int OP_W   = 4,
  parameter int COND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  logic              in_byte,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [DATA_W-1:0] in_src,
  input  logic [DATA_W-1:0] in_sr,
  input  logic [MASK_W-1:0] in_clr,
  input  logic [MASK_W-1:0] in_set,
  input  logic [MASK_W-1:0] in_upd,
  input  logic [COND_W-1:0] in_cond,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wr,
  output logic [DATA_W-1:0] out_sr,
  output logic              out_taken
);

  alu_op_e           op;
  logic              is_arith;
  logic              word_res;
  logic              writes;
  logic [DATA_W-1:0] ar_res;
  logic              ar_c;
  logic              ar_v;
  logic [DATA_W-1:0] lg_res;
  logic              lg_c;
  logic              lg_v;
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_c;
  logic              nxt_v;
  logic [DATA_W-1:0] nxt_sr;
  logic              nxt_taken;

  assign op       = alu_op_e'(in_op);
  assign is_arith = (op <= OP_DADD);
  assign word_res = !in_byte || (op == OP_SWPB) || (op == OP_SXT);
  assign writes   = !((op == OP_CMP) || (op == OP_BIT));

  alu16_arith #(.DATA_W(DATA_W)) u_arith (
    .op      (op),
    .byte_sz (in_byte),
    .a       (in_dst),
    .b       (in_src),
    .cin     (in_sr[SR_C]),
    .res     (ar_res),
    .c_out   (ar_c),
    .v_out   (ar_v)
  );

  alu16_logic #(.DATA_W(DATA_W)) u_logic (
    .op      (op),
    .byte_sz (in_byte),
    .a       (in_dst),
    .b       (in_src),
    .cin     (in_sr[SR_C]),
    .res     (lg_res),
    .c_out   (lg_c),
    .v_out   (lg_v)
  );

  assign nxt_res = is_arith ? ar_res : lg_res;
  assign nxt_c   = is_arith ? ar_c   : lg_c;
  assign nxt_v   = is_arith ? ar_v   : lg_v;

  alu16_flags #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_flags (
    .res      (nxt_res),
    .word_res (word_res),
    .calc_c   (nxt_c),
    .calc_v   (nxt_v),
    .sr_in    (in_sr),
    .clr_mask (in_clr),
    .set_mask (in_set),
    .upd_mask (in_upd),
    .cond     (cond_e'(in_cond)),
    .sr_out   (nxt_sr),
    .taken    (nxt_taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wr     <= 1'b0;
      out_sr     <= '0;
      out_taken  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= nxt_res;
        out_wr     <= writes;
        out_sr     <= nxt_sr;
        out_taken  <= nxt_taken;
      end
    end
  end

endmodule

// File: rtl/alu16_chk.sv
module alu16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [3:0]  in_op,
  input logic        in_byte,
  input logic [15:0] in_sr,
  input logic [3:0]  in_clr,
  input logic [3:0]  in_set,
  input logic [3:0]  in_upd,
  input logic [2:0]  in_cond,
  input logic        out_valid,
  input logic [15:0] out_result,
  input logic        out_wr,
  input logic [15:0] out_sr,
  input logic        out_taken
);
  logic       armed;
  logic [3:0] out_f;
  logic [3:0] in_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign out_f = {out_sr[8], out_sr[2], out_sr[1], out_sr[0]};
  assign in_f  = {in_sr[8], in_sr[2], in_sr[1], in_sr[0]};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid))); // R2

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_valid && ($past(in_op) == 4'd4 || $past(in_op) == 4'd7)) |-> !out_wr); // R4

  AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_valid && $past(in_byte) && $past(in_op) != 4'd14 && $past(in_op) != 4'd15)
      |-> (out_result[15:8] == 8'd0)); // R9

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_valid && $past(in_upd[1]) && !$past(in_set[1]))
      |-> (out_sr[1] == (out_result == 16'd0))); // R9

  AST_FORCED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_valid) |-> ((out_f & $past(in_set)) == $past(in_set))); // R10

  AST_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_valid)
      |-> (((out_f ^ $past(in_f)) & ~($past(in_clr) | $past(in_set) | $past(in_upd))) == 4'd0)); // R10

  AST_OTHER_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_valid)
      |-> ((out_sr & 16'hFEF8) == ($past(in_sr) & 16'hFEF8))); // R10

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_valid && $past(in_cond) == 3'd7) |-> out_taken); // R11

endmodule

bind alu16_top alu16_chk u_chk (.*);

// File: tb/alu16_top_tb.sv
module alu16_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_op = '0;
  logic        in_byte = 1'b0;
  logic [15:0] in_dst = '0;
  logic [15:0] in_src = '0;
  logic [15:0] in_sr = '0;
  logic [3:0]  in_clr = '0;
  logic [3:0]  in_set = '0;
  logic [3:0]  in_upd = '0;
  logic [2:0]  in_cond = '0;
  logic        out_valid;
  logic [15:0] out_result;
  logic        out_wr;
  logic [15:0] out_sr;
  logic        out_taken;

  int n_checks = 0;
  int n_errors = 0;

  // Expected-value queues, one entry per driven cycle
  int    q_valid[$];
  int    q_res[$];
  int    q_wr[$];
  int    q_sr[$];
  int    q_taken[$];
  string q_tag[$];
  int    held_res = 0, held_wr = 0, held_sr = 0, held_taken = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_byte(in_byte),
    .in_dst(in_dst), .in_src(in_src), .in_sr(in_sr), .in_clr(in_clr), .in_set(in_set),
    .in_upd(in_upd), .in_cond(in_cond), .out_valid(out_valid), .out_result(out_result),
    .out_wr(out_wr), .out_sr(out_sr), .out_taken(out_taken)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int sgn(input int x, input int w);
    return ((x >> (w - 1)) & 1) != 0 ? x - (1 << w) : x;
  endfunction

  function automatic int fits(input int s, input int w);
    return (s <= (1 << (w - 1)) - 1 && s >= -(1 << (w - 1))) ? 1 : 0;
  endfunction

  // Behavioural reference built from the requirements
  task automatic model(input int op, input int byt, input int dst, input int src, input int sr,
                       input int clr, input int set, input int upd, input int cond,
                       output int r, output int wr, output int nsr, output int tk);
    int w, m, a, b, ci, t, c, v, n, z, k, da, db, p, cur, comp, nf;
    w  = (byt != 0 && op != 14 && op != 15) ? 8 : 16;
    m  = (1 << w) - 1;
    a  = dst & m;
    b  = src & m;
    ci = sr & 1;
    c = 0; v = 0; wr = 1; r = 0;
    case (op)
      0, 1: begin
        k = (op == 1) ? ci : 0;
        t = a + b + k; r = t & m; c = (t > m);
        v = !fits(sgn(a, w) + sgn(b, w) + k, w);
      end
      2, 3, 4: begin
        k = (op == 3) ? ci : 1;
        t = a + ((~b) & m) + k; r = t & m; c = (t > m);
        v = !fits(sgn(a, w) - sgn(b, w) - 1 + k, w);
        wr = (op != 4);
      end
      5: begin
        da = 0; db = 0;
        for (int i = w / 4 - 1; i >= 0; i--) begin
          da = da * 10 + ((a >> (4 * i)) & 15);
          db = db * 10 + ((b >> (4 * i)) & 15);
        end
        t = da + db + ci;
        c = (t > ((w == 8) ? 99 : 9999));
        p = t;
        for (int i = 0; i < w / 4; i++) begin
          r = r | ((p % 10) << (4 * i));
          p = p / 10;
        end
      end
      6, 7: begin r = a & b; c = (r != 0); wr = (op != 7); end
      8: r = a & ~b & m;
      9: r = a | b;
      10: begin r = a ^ b; c = (r != 0); v = ((a >> (w-1)) & (b >> (w-1)) & 1); end
      11: begin r = (a >> 1) | (ci << (w - 1)); c = a & 1; end
      12: begin r = (a >> 1) | (a & (1 << (w - 1))); c = a & 1; end
      13: begin r = a >> 1; c = a & 1; end
      14: r = ((a >> 8) & 255) | ((a & 255) << 8);
      default: begin
        r = ((a & 128) != 0) ? ((a & 255) | 65280) : (a & 255);
        c = (r != 0);
      end
    endcase
    n = (r >> (w - 1)) & 1;
    z = (r == 0);
    cur  = (((sr >> 8) & 1) << 3) | (((sr >> 2) & 1) << 2) | (((sr >> 1) & 1) << 1) | (sr & 1);
    comp = (v << 3) | (n << 2) | (z << 1) | c;
    nf   = (((cur & ~clr & ~upd) | set) | (comp & upd)) & 15;
    nsr  = (sr & 'hFEF8) | (nf & 7) | (((nf >> 3) & 1) << 8);
    case (cond)
      0: tk = ((sr >> 1) & 1) == 0;
      1: tk = ((sr >> 1) & 1) == 1;
      2: tk = (sr & 1) == 0;
      3: tk = (sr & 1) == 1;
      4: tk = ((sr >> 2) & 1) == 1;
      5: tk = ((sr >> 2) & 1) == ((sr >> 8) & 1);
      6: tk = ((sr >> 2) & 1) != ((sr >> 8) & 1);
      default: tk = 1;
    endcase
  endtask

  task automatic compare_head();
    if (q_valid.size() > 0) begin
      string tg;
      tg = q_tag.pop_front();
      check(tg, "out_valid",  int'(out_valid),  q_valid.pop_front());
      check(tg, "out_result", int'(out_result), q_res.pop_front());
      check(tg, "out_wr",     int'(out_wr),     q_wr.pop_front());
      check(tg, "out_sr",     int'(out_sr),     q_sr.pop_front());
      check(tg, "out_taken",  int'(out_taken),  q_taken.pop_front());
    end
  endtask

  task automatic step(input int v, input int op, input int byt, input int dst, input int src,
                      input int sr, input int clr, input int set, input int upd, input int cond,
                      input string tag);
    int r, wr, nsr, tk;
    @(negedge clk);
    compare_head();
    in_valid = v[0];      in_op   = op[3:0];   in_byte = byt[0];
    in_dst   = dst[15:0]; in_src  = src[15:0]; in_sr   = sr[15:0];
    in_clr   = clr[3:0];  in_set  = set[3:0];  in_upd  = upd[3:0];
    in_cond  = cond[2:0];
    if (v != 0) begin
      model(op & 15, byt & 1, dst & 'hFFFF, src & 'hFFFF, sr & 'hFFFF,
            clr & 15, set & 15, upd & 15, cond & 7, r, wr, nsr, tk);
      held_res = r; held_wr = wr; held_sr = nsr; held_taken = tk;
    end
    q_valid.push_back(v & 1);
    q_res.push_back(held_res);
    q_wr.push_back(held_wr);
    q_sr.push_back(held_sr);
    q_taken.push_back(held_taken);
    q_tag.push_back(tag);
  endtask

  // Arithmetic/logic op with all flags updated, no forcing
  task automatic op_step(input int op, input int byt, input int dst, input int src,
                         input int sr, input string tag);
    step(1, op, byt, dst, src, sr, 0, 0, 15, 7, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    // R1: reset state while rst_n is low
    repeat (3) @(negedge clk);
    check("R1", "out_valid",  int'(out_valid),  0);
    check("R1", "out_result", int'(out_result), 0);
    check("R1", "out_wr",     int'(out_wr),     0);
    check("R1", "out_sr",     int'(out_sr),     0);
    check("R1", "out_taken",  int'(out_taken),  0);
    rst_n = 1'b1;

    // R3: add and add-with-carry
    op_step(0, 0, 'h7FFF, 'h0001, 0, "R3");       // 8000, V N
    op_step(1, 0, 'hFFFF, 'h0000, 1, "R3");       // 0000, C Z
    op_step(0, 0, 'h8000, 'h8000, 0, "R3");       // 0000, C Z V
    // R9: byte add ignores upper bits
    op_step(0, 1, 'h12FF, 'hAB01, 0, "R9");       // 00, C Z
    op_step(0, 1, 'hFF7F, 'h0001, 0, "R9");       // 80, V N
    // R4: subtract family and compare
    op_step(2, 0, 5, 7, 0, "R4");                 // FFFE, N, no carry
    op_step(3, 0, 5, 7, 0, "R4");                 // FFFD
    op_step(3, 0, 5, 7, 1, "R4");                 // FFFE
    op_step(4, 0, 'h8000, 1, 0, "R4");            // 7FFF, V C, no write
    op_step(2, 1, 'h0010, 'h0010, 0, "R4");       // 00, Z C
    // R5: decimal add
    op_step(5, 1, 'h0099, 'h0001, 0, "R5");       // 00, C
    op_step(5, 0, 'h1234, 'h8766, 0, "R5");       // 0000, C Z
    op_step(5, 0, 'h0405, 'h0005, 1, "R5");       // 0411
    op_step(5, 1, 'hAA45, 'h5538, 1, "R5");       // 84
    // R6: logical ops
    op_step(6, 0, 'hF0F0, 'h0F0F, 'h0107, "R6");  // 0000, Z
    op_step(7, 0, 'hF0F0, 'h8000, 0, "R6");       // bit-test, no write
    op_step(10, 0, 'h8000, 'h8001, 0, "R6");      // 0001, V C
    op_step(10, 1, 'h0080, 'h0080, 0, "R6");      // 00, V Z
    op_step(8, 0, 'hFFFF, 'h00F0, 0, "R6");       // FF0F
    op_step(9, 1, 'h1201, 'h3480, 0, "R6");       // 81
    // R7: rotate and shifts
    op_step(11, 0, 'h0001, 0, 1, "R7");           // 8000, C
    op_step(11, 1, 'h0002, 0, 1, "R7");           // 81
    op_step(12, 1, 'hFF81, 0, 0, "R7");           // C0, C
    op_step(12, 0, 'h8002, 0, 0, "R7");           // C001
    op_step(13, 0, 'h8001, 0, 1, "R7");           // 4000, C
    // R8: byte swap and sign extend (word even for byte size)
    op_step(14, 1, 'h12AB, 0, 0, "R8");           // AB12
    op_step(15, 1, 'h0080, 0, 0, "R8");           // FF80
    op_step(15, 0, 'hFF00, 0, 0, "R8");           // 0000, Z
    // R10: flag masks and pass-through
    step(1, 0, 0, 'h7FFF, 1, 'hFFFF, 0, 0, 0, 7, "R10");   // nothing changes
    step(1, 0, 0, 1, 1, 'hFEF8, 15, 0, 0, 7, "R10");       // all cleared
    step(1, 6, 0, 0, 0, 'h0000, 0, 15, 0, 7, "R10");       // all forced
    step(1, 0, 0, 'h7FFF, 1, 'h0107, 0, 0, 4, 7, "R10");   // only N recomputed
    step(1, 0, 0, 'hFFFF, 1, 'h0000, 1, 2, 1, 7, "R10");   // C computed, Z forced
    // R11: every branch condition over several status words
    for (int cd = 0; cd < 8; cd++) begin
      step(1, 9, 0, 0, 0, 'h0000, 0, 0, 0, cd, "R11");
      step(1, 9, 0, 0, 0, 'h0107, 0, 0, 0, cd, "R11");
      step(1, 9, 0, 0, 0, 'h0004, 0, 0, 0, cd, "R11");
      step(1, 9, 0, 0, 0, 'h0102, 0, 0, 0, cd, "R11");
    end
    // R2: idle cycles hold outputs and drop valid
    step(0, 0, 0, 'h1234, 'h1111, 'hFFFF, 15, 15, 15, 0, "R2");
    step(0, 5, 1, 'h9999, 'h0001, 0, 0, 0, 15, 3, "R2");
    op_step(1, 0, 'h0001, 'h0001, 1, "R2");
    // R2: mixed random traffic across all operations and masks
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 5) != 0, $urandom % 16, $urandom % 2, $urandom, $urandom,
           $urandom, $urandom % 16, ($urandom % 4 == 0) ? $urandom % 16 : 0,
           $urandom % 16, $urandom % 8, "R2");
    end
    @(negedge clk);
    compare_head();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule